// File: doc/BRIEF.md
# SHA-2 Message Schedule Expansion Unit

This block extends a SHA-2 message schedule by four words per element group. Each group brings twelve schedule words, spread out of order over three 4-word operand groups: a destination group and two source groups. The block combines them with the small sigma functions into the next four words, W16 to W19. Both SHA-256 (32-bit elements) and SHA-512 (64-bit elements) are handled. The sigma rotate and shift amounts follow the element width. A mode input decides whether 64-bit elements are permitted.

A request carries the instruction word, the element-width code, the vector length and the start index. Once accepted, the block walks the element groups from the start group to the last group, one group per cycle. For each group it presents the group index to an external register file and reads the three operand groups combinationally in the same cycle. It returns the four results as a write to the destination group. A one-cycle done pulse ends a successful run and tells the caller to clear its start index. A one-cycle illegal pulse rejects a request that has a reserved width, a misaligned length or a non-matching instruction word; such a request makes no write.

Top module: `sha2_sched_unit`

## Requirements
- R1: With element width code 2 (32-bit), sigma0 is ror7 ^ ror18 ^ shr3 and sigma1 is ror17 ^ ror19 ^ shr10 on bits [31:0] of each lane. Operand bits [63:32] are ignored, and result bits [63:32] of every lane are zero.
- R2: With element width code 3 (64-bit), sigma0 is ror1 ^ ror8 ^ shr7 and sigma1 is ror19 ^ ror61 ^ shr6 on the full 64-bit lane.
- R3: Lane k of a 256-bit group occupies bits [64k+63:64k]. Destination lanes 0..3 hold W0..W3. Second-source lanes 0..3 hold W4, W9, W10 and W11. First-source lanes 0..3 hold W12..W15.
- R4: W16 = s1(W14)+W9+s0(W1)+W0, W17 = s1(W15)+W10+s0(W2)+W1, W18 = s1(W16)+W11+s0(W3)+W2 and W19 = s1(W17)+W12+s0(W4)+W3. W18 and W19 use W16 and W17 from the same cycle, and every sum wraps modulo 2 to the element width.
- R5: `wr_en_o` is high for one cycle per group, with `wr_data_o` lanes 0..3 equal to W16..W19 for group `grp_idx_o`. The groups are written in ascending consecutive order, from vstart/4 to vl/4-1.
- R6: `done_o` pulses one cycle after the last write. If vstart/4 >= vl/4, `done_o` pulses one cycle after acceptance and nothing is written.
- R7: Width codes are 0=8, 1=16, 2=32 and 3=64 bits, with 4..7 reserved. With `dual_mode_i` low, any code other than 2 is illegal. With it high, any code other than 2 or 3 is illegal. `illegal_o` pulses one cycle after acceptance, with no write and no done.
- R8: A vector length whose bits [1:0] are nonzero is illegal, with the same effect as in R7.
- R9: The instruction matches when bits [31:25]=1011011, [14:12]=010 and [6:0]=1110111, and a mismatch is illegal. From the cycle after acceptance, `vd_idx_o`, `vs1_idx_o` and `vs2_idx_o` show bits [11:7], [19:15] and [24:20].
- R10: `req_ready_o` is high exactly while no group walk is in progress, out of reset and in the done cycle included. A request presented in the done cycle is accepted, and its first write follows one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted when high together with valid |
| insn_i | input | 32 | Instruction word |
| sew_i | input | 3 | Element width code |
| dual_mode_i | input | 1 | 1: 32- and 64-bit elements permitted; 0: 32-bit only |
| vl_i | input | VL_W | Vector length in elements |
| vstart_i | input | VL_W | Start index in elements |
| vd_idx_o | output | 5 | Destination register index |
| vs1_idx_o | output | 5 | First source register index |
| vs2_idx_o | output | 5 | Second source register index |
| grp_idx_o | output | VL_W-2 | Element group being read and written |
| vd_grp_i | input | 256 | Destination group read data |
| vs1_grp_i | input | 256 | First source group read data |
| vs2_grp_i | input | 256 | Second source group read data |
| wr_en_o | output | 1 | Result write strobe |
| wr_data_o | output | 256 | W16..W19 in lanes 0..3 |
| done_o | output | 1 | Successful completion pulse; start index to be cleared |
| illegal_o | output | 1 | Rejected-request pulse |

## Verification
Two functions can fall in the same cycle. The end of one group walk (the done pulse) can meet the acceptance of the next request. Separately, the two chained words W18 and W19 are formed in the same cycle as W16 and W17, which feed them. The bench holds a second request ready and presents it in the very cycle `done_o` is seen. It then expects the first write of the new run exactly one cycle later, with the write count of both runs intact. The same-cycle chain is judged against the published SHA-256 "abc" schedule words and an independent sigma/add model, for both element widths, with operands that force carries to wrap.

// File: rtl/sha2_sched_pkg.sv
package sha2_sched_pkg;
  localparam int ELEM_W = 64;
  localparam int LANES  = 4;
  localparam int GRP_W  = ELEM_W * LANES;

  localparam logic [2:0] SEW_CODE_32 = 3'd2;
  localparam logic [2:0] SEW_CODE_64 = 3'd3;

  localparam logic [6:0] ENC_HI7  = 7'b1011011;
  localparam logic [2:0] ENC_MID3 = 3'b010;
  localparam logic [6:0] ENC_OPC  = 7'b1110111;

  typedef enum logic {ST_IDLE, ST_RUN} sched_state_e;

  typedef struct packed {
    logic [4:0] vs2;
    logic [4:0] vs1;
    logic [4:0] vd;
  } reg_fields_t;
endpackage

// File: rtl/sha2_sched_decode.sv
module sha2_sched_decode
  import sha2_sched_pkg::*;
(
  input  logic [31:0] insn_i,
  output logic        match_o,
  output reg_fields_t fields_o
);
  assign match_o = (insn_i[31:25] == ENC_HI7) && (insn_i[14:12] == ENC_MID3) &&
                   (insn_i[6:0] == ENC_OPC);
  assign fields_o.vs2 = insn_i[24:20];
  assign fields_o.vs1 = insn_i[19:15];
  assign fields_o.vd  = insn_i[11:7];
endmodule

// File: rtl/sha2_sigma.sv
module sha2_sigma
  import sha2_sched_pkg::*;
#(
  parameter int ROT_A_32 = 7,
  parameter int ROT_B_32 = 18,
  parameter int SHR_32   = 3,
  parameter int ROT_A_64 = 1,
  parameter int ROT_B_64 = 8,
  parameter int SHR_64   = 7
) (
  input  logic [ELEM_W-1:0] x_i,
  input  logic              is64_i,
  output logic [ELEM_W-1:0] y_o
);
  localparam int HALF_W = ELEM_W / 2;

  logic [HALF_W-1:0] x_n, y_n;
  logic [ELEM_W-1:0] y_w;

  assign x_n = x_i[HALF_W-1:0];
  assign y_n = ((x_n >> ROT_A_32) | (x_n << (HALF_W - ROT_A_32))) ^
               ((x_n >> ROT_B_32) | (x_n << (HALF_W - ROT_B_32))) ^
               (x_n >> SHR_32);
  assign y_w = ((x_i >> ROT_A_64) | (x_i << (ELEM_W - ROT_A_64))) ^
               ((x_i >> ROT_B_64) | (x_i << (ELEM_W - ROT_B_64))) ^
               (x_i >> SHR_64);

  assign y_o = is64_i ? y_w : {{HALF_W{1'b0}}, y_n};
endmodule

// File: rtl/sha2_sched_core.sv
module sha2_sched_core
  import sha2_sched_pkg::*;
(
  input  logic [GRP_W-1:0] vd_grp_i,
  input  logic [GRP_W-1:0] vs1_grp_i,
  input  logic [GRP_W-1:0] vs2_grp_i,
  input  logic             is64_i,
  output logic [GRP_W-1:0] res_o
);
  localparam int HALF_W = ELEM_W / 2;

  function automatic logic [ELEM_W-1:0] fit(input logic [ELEM_W-1:0] v, input logic w64);
    return w64 ? v : {{HALF_W{1'b0}}, v[HALF_W-1:0]};
  endfunction

  logic [ELEM_W-1:0] w0, w1, w2, w3, w4, w9, w10, w11, w12, w14, w15;
  logic [ELEM_W-1:0] w16, w17, w18, w19;
  logic [ELEM_W-1:0] s0_in  [LANES];
  logic [ELEM_W-1:0] s0_out [LANES];
  logic [ELEM_W-1:0] s1_w14, s1_w15, s1_w16, s1_w17;
  logic              unused_w13;

  assign w0  = vd_grp_i[0*ELEM_W +: ELEM_W];
  assign w1  = vd_grp_i[1*ELEM_W +: ELEM_W];
  assign w2  = vd_grp_i[2*ELEM_W +: ELEM_W];
  assign w3  = vd_grp_i[3*ELEM_W +: ELEM_W];
  assign w4  = vs2_grp_i[0*ELEM_W +: ELEM_W];
  assign w9  = vs2_grp_i[1*ELEM_W +: ELEM_W];
  assign w10 = vs2_grp_i[2*ELEM_W +: ELEM_W];
  assign w11 = vs2_grp_i[3*ELEM_W +: ELEM_W];
  assign w12 = vs1_grp_i[0*ELEM_W +: ELEM_W];
  assign w14 = vs1_grp_i[2*ELEM_W +: ELEM_W];
  assign w15 = vs1_grp_i[3*ELEM_W +: ELEM_W];
  // W13 is never consumed by this step of the schedule
  assign unused_w13 = ^vs1_grp_i[1*ELEM_W +: ELEM_W];

  assign s0_in[0] = w1;
  assign s0_in[1] = w2;
  assign s0_in[2] = w3;
  assign s0_in[3] = w4;

  for (genvar k = 0; k < LANES; k++) begin : g_s0
    sha2_sigma #(.ROT_A_32(7), .ROT_B_32(18), .SHR_32(3),
                 .ROT_A_64(1), .ROT_B_64(8),  .SHR_64(7)) u_s0 (
      .x_i(s0_in[k]), .is64_i(is64_i), .y_o(s0_out[k]));
  end

  sha2_sigma #(.ROT_A_32(17), .ROT_B_32(19), .SHR_32(10),
               .ROT_A_64(19), .ROT_B_64(61), .SHR_64(6)) u_s1_a (
    .x_i(w14), .is64_i(is64_i), .y_o(s1_w14));
  sha2_sigma #(.ROT_A_32(17), .ROT_B_32(19), .SHR_32(10),
               .ROT_A_64(19), .ROT_B_64(61), .SHR_64(6)) u_s1_b (
    .x_i(w15), .is64_i(is64_i), .y_o(s1_w15));

  assign w16 = fit(s1_w14 + w9  + s0_out[0] + w0, is64_i);
  assign w17 = fit(s1_w15 + w10 + s0_out[1] + w1, is64_i);

  // second half of the chain consumes same-cycle W16/W17
  sha2_sigma #(.ROT_A_32(17), .ROT_B_32(19), .SHR_32(10),
               .ROT_A_64(19), .ROT_B_64(61), .SHR_64(6)) u_s1_c (
    .x_i(w16), .is64_i(is64_i), .y_o(s1_w16));
  sha2_sigma #(.ROT_A_32(17), .ROT_B_32(19), .SHR_32(10),
               .ROT_A_64(19), .ROT_B_64(61), .SHR_64(6)) u_s1_d (
    .x_i(w17), .is64_i(is64_i), .y_o(s1_w17));

  assign w18 = fit(s1_w16 + w11 + s0_out[2] + w2, is64_i);
  assign w19 = fit(s1_w17 + w12 + s0_out[3] + w3, is64_i);

  assign res_o = {w19, w18, w17, w16};
endmodule

// File: rtl/sha2_sched_ctrl.sv
module sha2_sched_ctrl
  import sha2_sched_pkg::*;
#(
  parameter int VL_W = 8,
  localparam int GI_W = VL_W - 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic            insn_match_i,
  input  reg_fields_t     fields_i,
  input  logic [2:0]      sew_i,
  input  logic            dual_mode_i,
  input  logic [VL_W-1:0] vl_i,
  input  logic [VL_W-1:0] vstart_i,
  output reg_fields_t     fields_o,
  output logic [GI_W-1:0] grp_idx_o,
  output logic            run_o,
  output logic            is64_o,
  output logic            done_o,
  output logic            illegal_o
);
  sched_state_e    state_q;
  logic [GI_W-1:0] cnt_q, last_q;
  logic            is64_q, done_q, ill_q;
  reg_fields_t     fields_q;

  logic            sew_ok, legal, empty;
  logic [GI_W-1:0] n_grp, start_grp;
  logic [1:0]      unused_vstart_lsb;

  assign n_grp             = vl_i[VL_W-1:2];
  assign start_grp         = vstart_i[VL_W-1:2];
  assign unused_vstart_lsb = vstart_i[1:0];

  assign sew_ok = (sew_i == SEW_CODE_32) || (dual_mode_i && (sew_i == SEW_CODE_64));
  assign legal  = sew_ok && (vl_i[1:0] == 2'b00) && insn_match_i;
  assign empty  = start_grp >= n_grp;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      last_q   <= '0;
      is64_q   <= 1'b0;
      done_q   <= 1'b0;
      ill_q    <= 1'b0;
      fields_q <= '0;
    end else begin
      done_q <= 1'b0;
      ill_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            fields_q <= fields_i;
            if (!legal) begin
              ill_q <= 1'b1;
            end else if (empty) begin
              done_q <= 1'b1;
            end else begin
              state_q <= ST_RUN;
              cnt_q   <= start_grp;
              last_q  <= n_grp - 1'b1;
              is64_q  <= (sew_i == SEW_CODE_64);
            end
          end
        end
        ST_RUN: begin
          if (cnt_q == last_q) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign run_o       = (state_q == ST_RUN);
  assign grp_idx_o   = cnt_q;
  assign is64_o      = is64_q;
  assign done_o      = done_q;
  assign illegal_o   = ill_q;
  assign fields_o    = fields_q;
endmodule

// File: rtl/sha2_sched_unit.sv
module sha2_sched_unit
  import sha2_sched_pkg::*;
#(
  parameter int VL_W = 8,
  localparam int GI_W = VL_W - 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [31:0]      insn_i,
  input  logic [2:0]       sew_i,
  input  logic             dual_mode_i,
  input  logic [VL_W-1:0]  vl_i,
  input  logic [VL_W-1:0]  vstart_i,
  output logic [4:0]       vd_idx_o,
  output logic [4:0]       vs1_idx_o,
  output logic [4:0]       vs2_idx_o,
  output logic [GI_W-1:0]  grp_idx_o,
  input  logic [GRP_W-1:0] vd_grp_i,
  input  logic [GRP_W-1:0] vs1_grp_i,
  input  logic [GRP_W-1:0] vs2_grp_i,
  output logic             wr_en_o,
  output logic [GRP_W-1:0] wr_data_o,
  output logic             done_o,
  output logic             illegal_o
);
  logic        insn_match, is64;
  reg_fields_t dec_fields, held_fields;

  sha2_sched_decode u_dec (
    .insn_i  (insn_i),
    .match_o (insn_match),
    .fields_o(dec_fields)
  );

  sha2_sched_ctrl #(.VL_W(VL_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .insn_match_i(insn_match),
    .fields_i    (dec_fields),
    .sew_i       (sew_i),
    .dual_mode_i (dual_mode_i),
    .vl_i        (vl_i),
    .vstart_i    (vstart_i),
    .fields_o    (held_fields),
    .grp_idx_o   (grp_idx_o),
    .run_o       (wr_en_o),
    .is64_o      (is64),
    .done_o      (done_o),
    .illegal_o   (illegal_o)
  );

  sha2_sched_core u_core (
    .vd_grp_i (vd_grp_i),
    .vs1_grp_i(vs1_grp_i),
    .vs2_grp_i(vs2_grp_i),
    .is64_i   (is64),
    .res_o    (wr_data_o)
  );

  assign vd_idx_o  = held_fields.vd;
  assign vs1_idx_o = held_fields.vs1;
  assign vs2_idx_o = held_fields.vs2;
endmodule

// File: rtl/sha2_sched_chk.sv
module sha2_sched_chk
  import sha2_sched_pkg::*;
#(
  parameter int VL_W = 8,
  localparam int GI_W = VL_W - 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [31:0]      insn_i,
  input logic [2:0]       sew_i,
  input logic             dual_mode_i,
  input logic [VL_W-1:0]  vl_i,
  input logic [GI_W-1:0]  grp_idx_o,
  input logic             wr_en_o,
  input logic [GRP_W-1:0] wr_data_o,
  input logic             done_o,
  input logic             illegal_o
);
  logic accept, narrow_q;
  assign accept = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) narrow_q <= 1'b0;
    else if (accept) narrow_q <= (sew_i != 3'd3);
  end

  p_narrow_hi_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && narrow_q) |-> (wr_data_o[63:32] == '0 && wr_data_o[127:96] == '0 &&
                               wr_data_o[191:160] == '0 && wr_data_o[255:224] == '0));

  p_grp_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && $past(wr_en_o)) |-> (grp_idx_o == $past(grp_idx_o) + 1'b1));

  p_done_after_last_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_en_o) |-> done_o);

  p_bad_sew_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !(sew_i == 3'd2 || (dual_mode_i && sew_i == 3'd3))) |=> (illegal_o && !done_o && !wr_en_o));

  p_flags_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && illegal_o));

  p_vl_align_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && vl_i[1:0] != 2'b00) |=> illegal_o);

  p_bad_insn_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && (insn_i[6:0] != 7'b1110111 || insn_i[14:12] != 3'b010 ||
                insn_i[31:25] != 7'b1011011)) |=> illegal_o);

  p_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> !req_ready_o);
endmodule

bind sha2_sched_unit sha2_sched_chk #(.VL_W(VL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .insn_i(insn_i), .sew_i(sew_i), .dual_mode_i(dual_mode_i), .vl_i(vl_i),
  .grp_idx_o(grp_idx_o), .wr_en_o(wr_en_o), .wr_data_o(wr_data_o),
  .done_o(done_o), .illegal_o(illegal_o)
);

// File: tb/sha2_sched_unit_tb_top.sv
`timescale 1ns/1ps
module sha2_sched_unit_tb_top;
  localparam int VL_W = 8;
  localparam int GI_W = VL_W - 2;
  localparam int NG   = 1 << GI_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [31:0]      insn = '0;
  logic [2:0]       sew = 3'd2;
  logic             dual = 1'b0;
  logic [VL_W-1:0]  vl = '0, vstart = '0;
  logic [4:0]       vd_idx, vs1_idx, vs2_idx;
  logic [GI_W-1:0]  grp_idx;
  logic [255:0]     vd_grp, vs1_grp, vs2_grp, wr_data;
  logic             wr_en, done, illegal;

  logic [255:0] vd_mem [NG];
  logic [255:0] vs1_mem [NG];
  logic [255:0] vs2_mem [NG];
  logic [255:0] res_mem [NG];

  int checks = 0, fails = 0, cyc = 0;
  int wr_cnt = 0, done_seen = 0, ill_seen = 0, seq_err = 0;
  int first_grp = -1, last_grp = -1;

  always #5 clk = ~clk;

  assign vd_grp  = vd_mem[grp_idx];
  assign vs1_grp = vs1_mem[grp_idx];
  assign vs2_grp = vs2_mem[grp_idx];

  sha2_sched_unit #(.VL_W(VL_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .insn_i(insn), .sew_i(sew), .dual_mode_i(dual), .vl_i(vl), .vstart_i(vstart),
    .vd_idx_o(vd_idx), .vs1_idx_o(vs1_idx), .vs2_idx_o(vs2_idx), .grp_idx_o(grp_idx),
    .vd_grp_i(vd_grp), .vs1_grp_i(vs1_grp), .vs2_grp_i(vs2_grp),
    .wr_en_o(wr_en), .wr_data_o(wr_data), .done_o(done), .illegal_o(illegal));

  // ---------------- behavioural model ----------------
  function automatic logic [63:0] rr(input logic [63:0] x, input int n, input bit w64);
    logic [127:0] d;
    logic [63:0]  l32;
    if (w64) begin d = {x, x}; return d[n +: 64]; end
    l32 = {x[31:0], x[31:0]};
    return {32'h0, l32[n +: 32]};
  endfunction

  function automatic logic [63:0] sg0(input logic [63:0] x, input bit w64);
    logic [63:0] v = w64 ? x : {32'h0, x[31:0]};
    return w64 ? (rr(v,1,1) ^ rr(v,8,1) ^ (v >> 7)) : (rr(v,7,0) ^ rr(v,18,0) ^ (v >> 3));
  endfunction

  function automatic logic [63:0] sg1(input logic [63:0] x, input bit w64);
    logic [63:0] v = w64 ? x : {32'h0, x[31:0]};
    return w64 ? (rr(v,19,1) ^ rr(v,61,1) ^ (v >> 6)) : (rr(v,17,0) ^ rr(v,19,0) ^ (v >> 10));
  endfunction

  function automatic logic [255:0] model(input logic [255:0] d, s1, s2, input bit w64);
    logic [63:0] w [20];
    logic [63:0] m = w64 ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0000_0000_FFFF_FFFF;
    for (int k = 0; k < 20; k++) w[k] = '0;
    for (int k = 0; k < 4; k++) begin
      w[k] = d[64*k +: 64] & m;
      w[12+k] = s1[64*k +: 64] & m;
    end
    w[4]  = s2[63:0] & m;    w[9]  = s2[127:64] & m;
    w[10] = s2[191:128] & m; w[11] = s2[255:192] & m;
    for (int t = 16; t < 20; t++)
      w[t] = (sg1(w[t-2], w64) + w[t-7] + sg0(w[t-15], w64) + w[t-16]) & m;
    return {w[19], w[18], w[17], w[16]};
  endfunction

  function automatic logic [31:0] enc(input logic [4:0] vd_f, vs1_f, vs2_f);
    return {7'b1011011, vs2_f, vs1_f, 3'b010, vd_f, 7'b1110111};
  endfunction

  // ---------------- monitor ----------------
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (wr_en) begin
      if (wr_cnt == 0) first_grp = int'(grp_idx);
      else if (int'(grp_idx) != last_grp + 1) seq_err++;
      last_grp = int'(grp_idx);
      wr_cnt++;
      res_mem[grp_idx] = wr_data;
    end
    if (done) done_seen++;
    if (illegal) ill_seen++;
  end

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clr_mon();
    wr_cnt = 0; done_seen = 0; ill_seen = 0; seq_err = 0; first_grp = -1; last_grp = -1;
    for (int g = 0; g < NG; g++) res_mem[g] = '0;
  endtask

  task automatic fill_rand(input int ng);
    for (int g = 0; g < ng; g++) begin
      for (int k = 0; k < 8; k++) begin
        vd_mem[g][32*k +: 32]  = $urandom;
        vs1_mem[g][32*k +: 32] = $urandom;
        vs2_mem[g][32*k +: 32] = $urandom;
      end
    end
  endtask

  task automatic run_op(input logic [31:0] i_w, input logic [2:0] s, input bit dm,
                        input int vlen, input int vst);
    clr_mon();
    @(negedge clk);
    insn = i_w; sew = s; dual = dm; vl = VL_W'(vlen); vstart = VL_W'(vst); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int t = 0; t < 200 && done_seen == 0 && ill_seen == 0; t++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic check_groups(input int g0, input int g1, input bit w64, input string tag);
    for (int g = g0; g <= g1; g++) begin
      logic [255:0] e = model(vd_mem[g], vs1_mem[g], vs2_mem[g], w64);
      chk(res_mem[g] === e, tag, res_mem[g], e);
    end
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk(req_ready === 1'b1, "R10 ready after reset", 256'(req_ready), 256'd1);
    chk({wr_en, done, illegal} === 3'b000, "R10 idle outputs after reset",
        256'({wr_en, done, illegal}), 256'd0);
  endtask

  task automatic t_abc();
    vd_mem[0]  = {64'h0, 64'h0, 64'h0, 64'hDEAD_BEEF_6162_6380};
    vs2_mem[0] = '0;
    vs1_mem[0] = {64'h0000_0000_0000_0018, 64'h0, 64'h0, 64'h0};
    run_op(enc(5'd1, 5'd2, 5'd3), 3'd2, 1'b0, 4, 0);
    chk(res_mem[0][31:0] === 32'h6162_6380, "R4 abc W16", 256'(res_mem[0][31:0]), 256'h6162_6380);
    chk(res_mem[0][95:64] === 32'h000F_0000, "R1 abc W17", 256'(res_mem[0][95:64]), 256'h000F_0000);
    chk(res_mem[0][223:192] === 32'h6000_03C6, "R4 abc W19 chained", 256'(res_mem[0][223:192]),
        256'h6000_03C6);
    check_groups(0, 0, 1'b0, "R1 abc model, upper operand bits ignored");
    chk(vd_idx === 5'd1 && vs1_idx === 5'd2 && vs2_idx === 5'd3, "R9 register indices",
        256'({vd_idx, vs1_idx, vs2_idx}), 256'({5'd1, 5'd2, 5'd3}));
  endtask

  task automatic t_multi32();
    fill_rand(8);
    run_op(enc(5'd8, 5'd16, 5'd24), 3'd2, 1'b1, 16, 0);
    chk(wr_cnt == 4 && first_grp == 0 && last_grp == 3 && seq_err == 0, "R5 32-bit group walk",
        256'(wr_cnt), 256'd4);
    check_groups(0, 3, 1'b0, "R3 32-bit placement and results");
    chk(done_seen == 1 && ill_seen == 0, "R6 done once", 256'(done_seen), 256'd1);
  endtask

  task automatic t_wide64();
    fill_rand(8);
    vd_mem[1]  = {256{1'b1}};
    vs1_mem[1] = {256{1'b1}};
    vs2_mem[1] = {256{1'b1}};
    run_op(enc(5'd4, 5'd5, 5'd6), 3'd3, 1'b1, 12, 5);
    chk(wr_cnt == 2 && first_grp == 1 && last_grp == 2, "R5 start group from vstart",
        256'(first_grp), 256'd1);
    check_groups(1, 2, 1'b1, "R2 64-bit sigma and wrap R4");
  endtask

  task automatic t_reserved();
    run_op(enc(5'd1, 5'd1, 5'd1), 3'd3, 1'b0, 8, 0);
    chk(ill_seen == 1 && wr_cnt == 0 && done_seen == 0, "R7 64-bit rejected in 32-only mode",
        256'(ill_seen), 256'd1);
    run_op(enc(5'd1, 5'd1, 5'd1), 3'd1, 1'b1, 8, 0);
    chk(ill_seen == 1 && wr_cnt == 0, "R7 code 1 rejected in dual mode", 256'(ill_seen), 256'd1);
    run_op(enc(5'd1, 5'd1, 5'd1), 3'd5, 1'b1, 8, 0);
    chk(ill_seen == 1 && wr_cnt == 0 && done_seen == 0, "R7 code 5 rejected", 256'(wr_cnt), 256'd0);
  endtask

  task automatic t_misaligned();
    run_op(enc(5'd1, 5'd1, 5'd1), 3'd2, 1'b0, 6, 0);
    chk(ill_seen == 1 && wr_cnt == 0, "R8 misaligned length", 256'(ill_seen), 256'd1);
  endtask

  task automatic t_bad_insn();
    logic [31:0] w = enc(5'd1, 5'd1, 5'd1);
    w[13] = 1'b0;
    run_op(w, 3'd2, 1'b0, 8, 0);
    chk(ill_seen == 1 && wr_cnt == 0, "R9 non-matching encoding", 256'(ill_seen), 256'd1);
  endtask

  task automatic t_empty();
    run_op(enc(5'd1, 5'd1, 5'd1), 3'd2, 1'b0, 8, 9);
    chk(done_seen == 1 && wr_cnt == 0 && ill_seen == 0, "R6 empty range done without write",
        256'(wr_cnt), 256'd0);
  endtask

  task automatic t_back_to_back();
    bit ok_rdy = 0, ok_first = 0;
    fill_rand(8);
    clr_mon();
    @(negedge clk);
    insn = enc(5'd2, 5'd3, 5'd4); sew = 3'd2; dual = 1'b0; vl = 8'd8; vstart = 8'd0;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int t = 0; t < 50 && !done; t++) @(negedge clk);
    ok_rdy = done && req_ready;
    sew = 3'd3; dual = 1'b1; vl = 8'd20; vstart = 8'd8; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    ok_first = wr_en && (grp_idx == 2);
    for (int t = 0; t < 50 && done_seen < 2; t++) @(negedge clk);
    @(negedge clk);
    chk(ok_rdy, "R10 ready in done cycle", 256'(ok_rdy), 256'd1);
    chk(ok_first, "R10 next run writes one cycle after done", 256'(ok_first), 256'd1);
    chk(wr_cnt == 5 && done_seen == 2, "R5 both runs complete", 256'(wr_cnt), 256'd5);
    check_groups(0, 1, 1'b0, "R1 back-to-back first run");
    check_groups(2, 4, 1'b1, "R2 back-to-back second run");
  endtask

  initial begin
    for (int g = 0; g < NG; g++) begin
      vd_mem[g] = '0; vs1_mem[g] = '0; vs2_mem[g] = '0; res_mem[g] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_abc();
    t_multi32();
    t_wide64();
    t_reserved();
    t_misaligned();
    t_bad_insn();
    t_empty();
    t_back_to_back();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule